// File: doc/BRIEF.md
# Programmable Defect Condition Detector

This block lets a processor recognise, at run time, a combination of internal events that is known to trigger a design defect, and raise a recovery request when that combination occurs. A vector of tapped status signals enters a selection stage. Each selection slot can be set to forward any one tapped signal. The selected signals feed a small programmable sum-of-products array. Every condition is the OR of several product terms. Each product term requires a chosen set of selected signals to be high or low.

All routing and term contents come from a configuration write port. Firmware loads them from stored defect signatures while the detector is disabled. A condition can run in one of two modes. In concurrent mode it needs all of its required signals in a single cycle. In complex mode it remembers signals that were high in earlier cycles, so events spread over time can still match. Each condition carries a class bit that tells the recovery logic whether the match happens before or after the defect takes effect. The request reports that bit together with the condition index.

Top module: `defect_cond_detector`

## Requirements
- R1: After synchronous reset, `cond_match`, `req_valid`, `req_idx` and `req_class` are all zero. All configuration is cleared, so no condition can match even once `det_en` is raised.
- R2: Selection slot s forwards tap `taps[k]`, where k is the value last written to address {region 0, index s} in data bits [3:0].
- R3: A product term is written at address {region 1, index c*2+t}, for term t of condition c. Data bits [7:0] are the care mask, [15:8] the required levels and [16] the enable. A term with enable 0 never matches. A cared slot whose required level is 0 must be low.
- R4: `cond_match[c]` goes high in the cycle after the selected inputs satisfy at least one enabled term of an enabled condition c. It is the OR of that condition's terms.
- R5: In concurrent mode, a term matches only when all of its cared slots have the required levels in the same cycle.
- R6: In complex mode, a cared slot with required level 1 is satisfied if that slot has been high in any cycle since the condition's history was last cleared, including the current cycle. A cared slot with required level 0 uses the current level.
- R7: A complex condition's history clears when the condition matches and when it is inactive (detector or condition disabled). After a match, a fresh set of events is needed for the next one.
- R8: Condition control is written at address {region 2, index c}: bit 0 enables the condition, bit 1 selects complex mode, and bit 2 is the class (0 pre-defect, 1 post-defect). Any configuration write made while `det_en` is high is ignored.
- R9: While `det_en` is low, no condition matches and no request is raised. Pending requests are discarded.
- R10: Whenever a condition matches, a request is present in the same cycle: `req_valid` is high, `req_idx` gives the reported condition and `req_class` gives its class bit.
- R11: When several conditions are pending, the lowest index is reported first, one per cycle. The others stay pending until reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| det_en | input | 1 | Detector enable; configuration writes are accepted only while low |
| taps | input | 16 | Tapped status signals |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 5 | Bits [4:3] region (0 selector, 1 term, 2 condition control), bits [2:0] index |
| cfg_wdata | input | 17 | Configuration word |
| cond_match | output | 4 | Per-condition match flag, one cycle after the inputs |
| req_valid | output | 1 | Recovery request present |
| req_idx | output | 2 | Index of the reported condition |
| req_class | output | 1 | Class of the reported condition (0 pre, 1 post) |

## Verification
The in-RTL properties watch the following on every cycle:
- configuration stays frozen across writes attempted while enabled;
- the block stays silent after a disabled cycle;
- a complex condition's history is empty after a match or a disable;
- at most one condition is granted;
- a pending request that was not granted survives;
- a match always comes with a request.

Other behaviours can only be shown by the bench's scenarios:
- the actual boolean content of the terms;
- complement levels;
- the way a complex condition accumulates events spread over time;
- the lowest-first reporting order over successive cycles.

The bench checks these against its own reference model, under both directed and random tap patterns.

// File: rtl/dcd_pkg.sv
package dcd_pkg;
    parameter int NUM_TAPS  = 16;
    parameter int NUM_SEL   = 8;
    parameter int NUM_COND  = 4;
    parameter int NUM_TERMS = 2;

    localparam int TAP_W     = $clog2(NUM_TAPS);
    localparam int COND_W    = $clog2(NUM_COND);
    localparam int NUM_TSLOT = NUM_COND * NUM_TERMS;
    localparam int IDX_SPAN  = (NUM_SEL > NUM_TSLOT) ? NUM_SEL : NUM_TSLOT;
    localparam int IDX_W     = $clog2(IDX_SPAN);
    localparam int ADDR_W    = IDX_W + 2;
    localparam int CFG_DW    = 2 * NUM_SEL + 1;

    typedef enum logic [1:0] {
        RGN_SEL  = 2'd0,
        RGN_TERM = 2'd1,
        RGN_COND = 2'd2,
        RGN_NONE = 2'd3
    } cfg_rgn_e;

    typedef enum logic {
        CLS_PRE  = 1'b0,
        CLS_POST = 1'b1
    } dcd_class_e;

    // Product term: enable in the MSB, then required levels, then care mask.
    typedef struct packed {
        logic               en;
        logic [NUM_SEL-1:0] val;
        logic [NUM_SEL-1:0] care;
    } term_cfg_t;

    // Condition control: enable in bit 0, complex mode bit 1, class bit 2.
    typedef struct packed {
        dcd_class_e cls;
        logic       cplx;
        logic       en;
    } cond_cfg_t;

    // Level-1 care bits look at the history view, level-0 care bits at now.
    function automatic logic term_hit(term_cfg_t t,
                                      logic [NUM_SEL-1:0] seen,
                                      logic [NUM_SEL-1:0] now);
        return t.en
            && ((t.care &  t.val & ~seen) == '0)
            && ((t.care & ~t.val &  now)  == '0);
    endfunction
endpackage

// File: rtl/dcd_selector.sv
module dcd_selector
    import dcd_pkg::*;
(
    input  logic [NUM_TAPS-1:0]           taps,
    input  logic [NUM_SEL-1:0][TAP_W-1:0] sel_idx,
    output logic [NUM_SEL-1:0]            sel_out
);
    for (genvar g = 0; g < NUM_SEL; g++) begin : g_slot
        assign sel_out[g] = taps[sel_idx[g]];
    end
endmodule

// File: rtl/dcd_cond_eval.sv
module dcd_cond_eval
    import dcd_pkg::*;
#(
    parameter int NTERM = NUM_TERMS
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        active,
    input  logic                        cplx,
    input  logic [NUM_SEL-1:0]          sel_now,
    input  term_cfg_t [NTERM-1:0]       terms,
    output logic                        hit
);
    logic [NUM_SEL-1:0] sticky;
    logic [NUM_SEL-1:0] seen;
    logic               any_term;

    always_comb begin
        seen     = cplx ? (sticky | sel_now) : sel_now;
        any_term = 1'b0;
        for (int t = 0; t < NTERM; t++) begin
            any_term = any_term | term_hit(terms[t], seen, sel_now);
        end
        hit = active & any_term;
    end

    always_ff @(posedge clk) begin
        if (rst || !active || hit || !cplx) begin
            sticky <= '0;
        end else begin
            sticky <= sticky | sel_now;
        end
    end

    // R7
    sticky_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (hit || !active) |=> (sticky == '0));
endmodule

// File: rtl/dcd_arbiter.sv
module dcd_arbiter
    import dcd_pkg::*;
(
    input  logic [NUM_COND-1:0] pend,
    output logic [NUM_COND-1:0] grant,
    output logic [COND_W-1:0]   gidx,
    output logic                gvalid
);
    always_comb begin
        gidx = '0;
        for (int i = NUM_COND - 1; i >= 0; i--) begin
            if (pend[i]) gidx = COND_W'(i);
        end
        gvalid = |pend;
        grant  = gvalid ? (NUM_COND'(1) << gidx) : '0;
    end
endmodule

// File: rtl/defect_cond_detector.sv
module defect_cond_detector
    import dcd_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                det_en,
    input  logic [15:0]         taps,
    input  logic                cfg_we,
    input  logic [4:0]          cfg_addr,
    input  logic [16:0]         cfg_wdata,
    output logic [3:0]          cond_match,
    output logic                req_valid,
    output logic [1:0]          req_idx,
    output logic                req_class
);
    logic [NUM_SEL-1:0][TAP_W-1:0]  sel_idx;
    term_cfg_t [NUM_TSLOT-1:0]      terms;
    cond_cfg_t [NUM_COND-1:0]       conds;

    logic [NUM_SEL-1:0]  sel_vec;
    logic [NUM_COND-1:0] hit;
    logic [NUM_COND-1:0] match_q;
    logic [NUM_COND-1:0] pend;
    logic [NUM_COND-1:0] grant;
    logic [COND_W-1:0]   gidx;
    logic                gvalid;

    cfg_rgn_e         wr_rgn;
    logic [IDX_W-1:0] wr_idx;

    assign wr_rgn = cfg_rgn_e'(cfg_addr[ADDR_W-1 -: 2]);
    assign wr_idx = cfg_addr[IDX_W-1:0];

    // Configuration store: frozen while the detector runs.
    always_ff @(posedge clk) begin
        if (rst) begin
            sel_idx <= '0;
            terms   <= '0;
            conds   <= '0;
        end else if (cfg_we && !det_en) begin
            unique case (wr_rgn)
                RGN_SEL: begin
                    for (int i = 0; i < NUM_SEL; i++) begin
                        if (wr_idx == IDX_W'(i)) sel_idx[i] <= cfg_wdata[TAP_W-1:0];
                    end
                end
                RGN_TERM: begin
                    for (int i = 0; i < NUM_TSLOT; i++) begin
                        if (wr_idx == IDX_W'(i)) terms[i] <= term_cfg_t'(cfg_wdata);
                    end
                end
                RGN_COND: begin
                    for (int i = 0; i < NUM_COND; i++) begin
                        if (wr_idx == IDX_W'(i)) conds[i] <= cond_cfg_t'(cfg_wdata[2:0]);
                    end
                end
                default: ;
            endcase
        end
    end

    dcd_selector u_sel (
        .taps    (taps),
        .sel_idx (sel_idx),
        .sel_out (sel_vec)
    );

    for (genvar c = 0; c < NUM_COND; c++) begin : g_cond
        dcd_cond_eval #(.NTERM(NUM_TERMS)) u_eval (
            .clk     (clk),
            .rst     (rst),
            .active  (det_en & conds[c].en),
            .cplx    (conds[c].cplx),
            .sel_now (sel_vec),
            .terms   (terms[c*NUM_TERMS +: NUM_TERMS]),
            .hit     (hit[c])
        );
    end

    dcd_arbiter u_arb (
        .pend   (pend),
        .grant  (grant),
        .gidx   (gidx),
        .gvalid (gvalid)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            match_q <= '0;
            pend    <= '0;
        end else begin
            match_q <= hit;
            pend    <= det_en ? ((pend & ~grant) | hit) : '0;
        end
    end

    assign cond_match = match_q;
    assign req_valid  = gvalid;
    assign req_idx    = gidx;
    assign req_class  = gvalid ? logic'(conds[gidx].cls) : 1'b0;

    // R8
    cfg_locked_chk: assert property (@(posedge clk) disable iff (rst)
        (det_en && cfg_we) |=> ($stable(sel_idx) && $stable(terms) && $stable(conds)));

    // R9
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !det_en |=> ((cond_match == '0) && !req_valid));

    // R10
    req_on_match_chk: assert property (@(posedge clk) disable iff (rst)
        (cond_match != '0) |-> req_valid);

    // R11
    grant_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));

    // R11
    pend_hold_chk: assert property (@(posedge clk) disable iff (rst)
        det_en |=> ((($past(pend) & ~$past(grant)) & ~pend) == '0));
endmodule

// File: tb/defect_cond_detector_bench.sv
`timescale 1ns/1ps
module defect_cond_detector_bench;
    import dcd_pkg::*;

    localparam time CLK = 20;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                det_en = 1'b0;
    logic [15:0]         taps = '0;
    logic                cfg_we = 1'b0;
    logic [4:0]          cfg_addr = '0;
    logic [16:0]         cfg_wdata = '0;
    logic [3:0]          cond_match;
    logic                req_valid;
    logic [1:0]          req_idx;
    logic                req_class;

    defect_cond_detector u_defect_cond_detector (
        .clk(clk), .rst(rst), .det_en(det_en), .taps(taps),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cond_match(cond_match), .req_valid(req_valid),
        .req_idx(req_idx), .req_class(req_class)
    );

    always #(CLK/2) clk = ~clk;

    int n_chk  = 0;
    int n_fail = 0;

    // Reference model state
    logic [TAP_W-1:0]    m_sel    [NUM_SEL];
    logic [CFG_DW-1:0]   m_term   [NUM_TSLOT];
    logic [2:0]          m_cond   [NUM_COND];
    logic [NUM_SEL-1:0]  m_sticky [NUM_COND];
    logic [NUM_COND-1:0] m_pend;
    logic [NUM_COND-1:0] m_match;

    task automatic check(bit ok, string tag, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic int lowest(logic [NUM_COND-1:0] v);
        for (int i = 0; i < NUM_COND; i++) if (v[i]) return i;
        return 0;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < NUM_SEL; i++) m_sel[i] = '0;
        for (int i = 0; i < NUM_TSLOT; i++) m_term[i] = '0;
        for (int i = 0; i < NUM_COND; i++) begin
            m_cond[i] = '0;
            m_sticky[i] = '0;
        end
        m_pend  = '0;
        m_match = '0;
    endtask

    task automatic model_tick(logic [15:0] tv, logic en, logic we,
                              logic [4:0] addr, logic [16:0] data);
        logic [NUM_SEL-1:0]  selv;
        logic [NUM_COND-1:0] hv;
        logic [NUM_COND-1:0] g;
        for (int s = 0; s < NUM_SEL; s++) selv[s] = tv[m_sel[s]];
        for (int c = 0; c < NUM_COND; c++) begin
            logic act, cp, h;
            logic [NUM_SEL-1:0] seen, care, val;
            act  = en & m_cond[c][0];
            cp   = m_cond[c][1];
            seen = cp ? (m_sticky[c] | selv) : selv;
            h    = 1'b0;
            for (int t = 0; t < NUM_TERMS; t++) begin
                logic [16:0] w;
                w    = m_term[c*NUM_TERMS + t];
                care = w[7:0];
                val  = w[15:8];
                if (w[16] && ((care & val & ~seen) == 0) && ((care & ~val & selv) == 0)) h = 1'b1;
            end
            h = h & act;
            hv[c] = h;
            m_sticky[c] = (!act || h || !cp) ? '0 : (m_sticky[c] | selv);
        end
        g = (m_pend != 0) ? (NUM_COND'(1) << lowest(m_pend)) : '0;
        m_pend  = en ? ((m_pend & ~g) | hv) : '0;
        m_match = hv;
        if (we && !en) begin
            int ix;
            ix = int'(addr[2:0]);
            case (addr[4:3])
                2'd0: if (ix < NUM_SEL)   m_sel[ix]  = data[TAP_W-1:0];
                2'd1: if (ix < NUM_TSLOT) m_term[ix] = data;
                2'd2: if (ix < NUM_COND)  m_cond[ix] = data[2:0];
                default: ;
            endcase
        end
    endtask

    task automatic compare(string tag);
        int ei;
        check(cond_match == m_match, tag, "cond_match", int'(cond_match), int'(m_match));
        check(req_valid == (m_pend != 0), tag, "req_valid", int'(req_valid), int'(m_pend != 0));
        if (m_pend != 0) begin
            ei = lowest(m_pend);
            check(req_idx == 2'(ei), tag, "req_idx", int'(req_idx), ei);
            check(req_class == m_cond[ei][2], tag, "req_class", int'(req_class), int'(m_cond[ei][2]));
        end
    endtask

    // One cycle: drive at negedge, model, then sample at next negedge.
    task automatic cyc(logic [15:0] tv, logic en, logic we, logic [4:0] addr,
                       logic [16:0] data, string tag);
        taps = tv; det_en = en; cfg_we = we; cfg_addr = addr; cfg_wdata = data;
        model_tick(tv, en, we, addr, data);
        @(posedge clk);
        @(negedge clk);
        cfg_we = 1'b0;
        compare(tag);
    endtask

    // Selection slot i is routed to tap 2*i+1 in the directed part.
    function automatic logic [15:0] tvec(logic [7:0] s);
        logic [15:0] v = '0;
        for (int i = 0; i < 8; i++) v[2*i+1] = s[i];
        return v;
    endfunction

    task automatic wr(logic [1:0] rgn, int ix, logic [16:0] data, string tag);
        cyc(16'h0, 1'b0, 1'b1, {rgn, 3'(ix)}, data, tag);
    endtask

    initial begin
        #(CLK * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL R1 watchdog: got 0 expected 1");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        compare("R1");
        cyc(16'hFFFF, 1'b1, 1'b0, 5'd0, 17'd0, "R1");
        cyc(16'hA5A5, 1'b1, 1'b0, 5'd0, 17'd0, "R1");

        // R2: routing
        for (int i = 0; i < NUM_SEL; i++) wr(2'd0, i, 17'(2*i+1), "R2");
        // R3: term words {en, val, care}
        wr(2'd1, 0, {1'b1, 8'h01, 8'h01}, "R3");
        wr(2'd1, 1, {1'b1, 8'h0E, 8'h0E}, "R3");
        wr(2'd1, 2, {1'b1, 8'h30, 8'h30}, "R3");
        wr(2'd1, 4, {1'b1, 8'h80, 8'hC0}, "R3");
        wr(2'd1, 6, {1'b0, 8'h00, 8'h00}, "R3");
        // R8: control words {cls, cplx, en}
        wr(2'd2, 0, 17'b001, "R8");
        wr(2'd2, 1, 17'b111, "R8");
        wr(2'd2, 2, 17'b101, "R8");
        wr(2'd2, 3, 17'b001, "R8");

        cyc(tvec(8'h00), 1'b1, 1'b0, 5'd0, 17'd0, "R3");
        cyc(tvec(8'h01), 1'b1, 1'b0, 5'd0, 17'd0, "R4");
        cyc(tvec(8'h00), 1'b1, 1'b0, 5'd0, 17'd0, "R4");
        cyc(tvec(8'h0E), 1'b1, 1'b0, 5'd0, 17'd0, "R4");
        cyc(tvec(8'h06), 1'b1, 1'b0, 5'd0, 17'd0, "R5");
        cyc(tvec(8'h02), 1'b1, 1'b0, 5'd0, 17'd0, "R5");
        cyc(tvec(8'h04), 1'b1, 1'b0, 5'd0, 17'd0, "R5");
        cyc(tvec(8'h08), 1'b1, 1'b0, 5'd0, 17'd0, "R5");
        cyc(tvec(8'h10), 1'b1, 1'b0, 5'd0, 17'd0, "R6");
        cyc(tvec(8'h00), 1'b1, 1'b0, 5'd0, 17'd0, "R6");
        cyc(tvec(8'h20), 1'b1, 1'b0, 5'd0, 17'd0, "R6");
        cyc(tvec(8'h20), 1'b1, 1'b0, 5'd0, 17'd0, "R7");
        cyc(tvec(8'h10), 1'b1, 1'b0, 5'd0, 17'd0, "R7");
        cyc(tvec(8'h80), 1'b1, 1'b0, 5'd0, 17'd0, "R10");
        cyc(tvec(8'hC0), 1'b1, 1'b0, 5'd0, 17'd0, "R3");
        cyc(tvec(8'h81), 1'b1, 1'b0, 5'd0, 17'd0, "R11");
        cyc(tvec(8'h00), 1'b1, 1'b0, 5'd0, 17'd0, "R11");
        cyc(tvec(8'h00), 1'b1, 1'b0, 5'd0, 17'd0, "R11");
        cyc(tvec(8'h10), 1'b1, 1'b0, 5'd0, 17'd0, "R7");
        cyc(tvec(8'h10), 1'b0, 1'b0, 5'd0, 17'd0, "R9");
        cyc(tvec(8'h20), 1'b1, 1'b0, 5'd0, 17'd0, "R7");
        cyc(tvec(8'h00), 1'b1, 1'b1, 5'd0, 17'd0, "R8");
        cyc(tvec(8'h01), 1'b1, 1'b0, 5'd0, 17'd0, "R8");
        cyc(tvec(8'h01), 1'b0, 1'b0, 5'd0, 17'd0, "R9");
        cyc(tvec(8'h00), 1'b1, 1'b0, 5'd0, 17'd0, "R9");

        // Random mix: reconfiguration while disabled, random taps while enabled.
        for (int n = 0; n < 4000; n++) begin
            logic [15:0] tv;
            tv = 16'($urandom);
            if (($urandom % 50) == 0) begin
                for (int k = 0; k < 4; k++) begin
                    logic [4:0]  a;
                    logic [16:0] d;
                    a = 5'($urandom);
                    d = 17'($urandom);
                    if (a[4:3] == 2'd1) d[7:0] = d[7:0] & 8'($urandom) & 8'($urandom);
                    cyc(tv, 1'b0, 1'b1, a, d, "R8");
                end
            end else begin
                cyc(tv, ($urandom % 16) != 0, ($urandom % 8) == 0, 5'($urandom),
                    17'($urandom), "R4");
            end
        end

        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule